// File: doc/BRIEF.md
# Segment-Stage Translation and Fault Syndrome Unit

This unit carries out the segment step of translating a 32-bit effective address. It keeps sixteen segment registers written by software. For each request it picks one register with the top four address bits. From that register and the address it works out, in the same cycle, the page index, the hash and the compare tag that a separate TLB uses for its search. The TLB answers in that same cycle with miss and protection flags. The unit then settles the outcome of the access: plain success, TLB miss, protection fault, no-execute fault, direct-store fault, or a direct-store pass-through.

One clock after the request the unit registers a full syndrome and holds it until the next request. The syndrome contains the faulting address, the compare word, the primary and secondary page-table group addresses for a software refill handler, a data-fault status word and a set of syndrome flags. The page-table base and a size code are written by software. The page-table group addresses are built from the hash and from its complement.

Top module: `segx_top`

## Requirements
- R1: A segment-register write stores srWrData at index srWrIdx. A request uses the register selected by reqAddr[31:28]. Register fields: bit 31 direct-store (T), bit 30 supervisor key, bit 29 user key, bit 28 no-execute (N), bits 23:0 segment id (VSID). The key is the user key when reqUser is 1, otherwise the supervisor key.
- R2: Combinationally from reqAddr: srchPgIdx = reqAddr[27:12], srchHash = VSID XOR srchPgIdx (24 bits), srchTag = (VSID << 7) OR (srchPgIdx >> 10).
- R3: A cycle with reqValid high captures the result. doneValid is high in the next cycle only. All registered outputs hold their values until the next request.
- R4: In a segment with T=0, a fetch (reqFetch=1) with N=1 gives faultClass 3 with syndFlags 0x10000000, whatever the TLB flags are.
- R5: In a segment with T=0 (and no R4 fault), tlbMiss=1 gives faultClass 1, faultAddr = reqAddr and cmpReg = srchTag OR 0x80000000. syndFlags has bit 19 = key, bit 18 = fetch, and bit 16 = store when the access is not a fetch.
- R6: On a miss, hashAddr1 = base + ((hash AND mask) << 6) and hashAddr2 = base + ((NOT hash AND mask) << 6). The mask has its low 10+cfgSize bits set, capped at 24 bits. cfgBase and cfgSize are loaded when cfgWrEn is high.
- R7: With T=0, tlbProt=1 and tlbMiss=0 give faultClass 2 with faultAddr = reqAddr. For data accesses statusWord is 0x0A000000 on a store and 0x08000000 on a load. For a fetch, syndFlags is 0x08000000 and statusWord is 0.
- R8: With T=0 and no fault, faultClass is 0 and every syndrome output is zero.
- R9: With T=1, these accesses give faultClass 4 with faultAddr = reqAddr: a fetch (syndFlags 0x10000000); kind 1, float (status 0); kind 2, reserved (status 0x06000000 store, 0x04000000 load); kind 3, external-control (status 0x06100000 store, 0x04100000 load). The TLB flags are ignored.
- R10: With T=1, kind 4 (cache op) gives faultClass 5 with realAddr = reqAddr. Kind 0 (integer) also gives faultClass 5 for a load with key 0 or a store with key 1. Any other integer access gives faultClass 2 with the R7 data status words. realAddr is zero in every class other than 5.
- R11: After reset, all registered outputs, segment registers, base and size are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srWrEn | input | 1 | Segment register write strobe |
| srWrIdx | input | 4 | Segment register index |
| srWrData | input | 32 | Segment register write value |
| cfgWrEn | input | 1 | Page-table base/size write strobe |
| cfgBase | input | 32 | Page-table base address |
| cfgSize | input | 4 | Page-table size code |
| reqValid | input | 1 | Translation request |
| reqAddr | input | 32 | Effective address |
| reqFetch | input | 1 | Access is an instruction fetch |
| reqStore | input | 1 | Data access is a store |
| reqUser | input | 1 | Access is at user privilege |
| reqKind | input | 3 | Data access kind (0 int, 1 float, 2 reserved, 3 external, 4 cache) |
| srchHash | output | 24 | Primary hash for TLB search |
| srchPgIdx | output | 16 | Page index within segment |
| srchTag | output | 32 | Compare tag for TLB search |
| tlbMiss | input | 1 | TLB reports no match |
| tlbProt | input | 1 | TLB reports access rights violation |
| doneValid | output | 1 | Syndrome updated this cycle |
| faultClass | output | 3 | 0 ok, 1 miss, 2 prot, 3 no-exec, 4 direct-store fault, 5 direct-store pass |
| faultAddr | output | 32 | Faulting effective address |
| cmpReg | output | 32 | Compare word with valid bit 31 |
| hashAddr1 | output | 32 | Primary page-table group address |
| hashAddr2 | output | 32 | Secondary page-table group address |
| statusWord | output | 32 | Data fault status code |
| syndFlags | output | 32 | Syndrome flag word |
| realAddr | output | 32 | Untranslated pass-through address |

## Verification
Requests are generated at random across all sixteen segments, with T, N and both key bits drawn freely. Fetch, load and store are mixed over every access kind, and the TLB flags are set independently, so each outcome class appears against the others. Directed cases separate the no-execute check from a plain fetch miss, and the load status word from the store word. They pin down key placement under both privileges and the direct-store integer key rule in all four combinations. The largest size code checks that the group mask stops at 24 bits. Idle cycles with moving inputs after each request show that the syndrome holds.

// File: rtl/segx_pkg.sv
package segx_pkg;
  localparam int EA_W          = 32;
  localparam int SEG_SEL_W     = 4;
  localparam int NSEG          = 1 << SEG_SEL_W;
  localparam int PAGE_BITS     = 12;
  localparam int VSID_W        = 24;
  localparam int PG_W          = EA_W - SEG_SEL_W - PAGE_BITS;
  localparam int API_SHIFT     = 10;
  localparam int TAG_SHIFT     = 7;
  localparam int GROUP_SHIFT   = 6;
  localparam int MIN_MASK_BITS = 10;
  localparam int SIZE_W        = 4;
  localparam int KIND_W        = 3;

  typedef enum logic [2:0] {
    FC_OK      = 3'd0,
    FC_MISS    = 3'd1,
    FC_PROT    = 3'd2,
    FC_NOEXEC  = 3'd3,
    FC_DSFAULT = 3'd4,
    FC_DSPASS  = 3'd5
  } faultClass_e;

  typedef enum logic [KIND_W-1:0] {
    AK_INT   = 3'd0,
    AK_FLOAT = 3'd1,
    AK_RESV  = 3'd2,
    AK_EXT   = 3'd3,
    AK_CACHE = 3'd4
  } accKind_e;

  typedef struct packed {
    logic              cap;
    faultClass_e       fClass;
    logic              ldMiss;
    logic              ldFault;
    logic              ldReal;
    logic [EA_W-1:0]   status;
    logic [EA_W-1:0]   synd;
  } strobe_t;
endpackage

// File: rtl/segx_ctrl.sv
module segx_ctrl
  import segx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqFetch,
  input  logic              reqStore,
  input  logic [KIND_W-1:0] reqKind,
  input  logic              segT,
  input  logic              segN,
  input  logic              segKey,
  input  logic              tlbMiss,
  input  logic              tlbProt,
  output strobe_t           stb,
  output logic              doneValid
);
  localparam logic [EA_W-1:0] NOEXEC_CODE   = 32'h1000_0000;
  localparam logic [EA_W-1:0] PROT_LD_CODE  = 32'h0800_0000;
  localparam logic [EA_W-1:0] PROT_ST_CODE  = 32'h0A00_0000;
  localparam logic [EA_W-1:0] RESV_LD_CODE  = 32'h0400_0000;
  localparam logic [EA_W-1:0] RESV_ST_CODE  = 32'h0600_0000;
  localparam logic [EA_W-1:0] EXT_LD_CODE   = 32'h0410_0000;
  localparam logic [EA_W-1:0] EXT_ST_CODE   = 32'h0610_0000;

  logic            isStore;
  logic [EA_W-1:0] protStatus;

  assign isStore    = reqStore & ~reqFetch;
  assign protStatus = isStore ? PROT_ST_CODE : PROT_LD_CODE;

  always_comb begin
    stb        = '0;
    stb.fClass = FC_OK;
    stb.cap    = reqValid;
    if (!segT) begin
      if (reqFetch && segN) begin
        stb.fClass  = FC_NOEXEC;
        stb.synd    = NOEXEC_CODE;
        stb.ldFault = 1'b1;
      end else if (tlbMiss) begin
        stb.fClass  = FC_MISS;
        stb.ldMiss  = 1'b1;
        stb.ldFault = 1'b1;
        stb.synd    = {12'd0, segKey, reqFetch, 1'b0, isStore, 16'd0};
      end else if (tlbProt) begin
        stb.fClass  = FC_PROT;
        stb.ldFault = 1'b1;
        if (reqFetch) stb.synd   = PROT_LD_CODE;
        else          stb.status = protStatus;
      end
    end else if (reqFetch) begin
      stb.fClass  = FC_DSFAULT;
      stb.synd    = NOEXEC_CODE;
      stb.ldFault = 1'b1;
    end else begin
      case (reqKind)
        AK_CACHE: begin
          stb.fClass = FC_DSPASS;
          stb.ldReal = 1'b1;
        end
        AK_FLOAT: begin
          stb.fClass  = FC_DSFAULT;
          stb.ldFault = 1'b1;
        end
        AK_RESV: begin
          stb.fClass  = FC_DSFAULT;
          stb.ldFault = 1'b1;
          stb.status  = isStore ? RESV_ST_CODE : RESV_LD_CODE;
        end
        AK_EXT: begin
          stb.fClass  = FC_DSFAULT;
          stb.ldFault = 1'b1;
          stb.status  = isStore ? EXT_ST_CODE : EXT_LD_CODE;
        end
        default: begin
          if (isStore == segKey) begin
            stb.fClass = FC_DSPASS;
            stb.ldReal = 1'b1;
          end else begin
            stb.fClass  = FC_PROT;
            stb.ldFault = 1'b1;
            stb.status  = protStatus;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) doneValid <= 1'b0;
    else       doneValid <= reqValid;
  end
endmodule

// File: rtl/segx_dpath.sv
module segx_dpath
  import segx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 srWrEn,
  input  logic [SEG_SEL_W-1:0] srWrIdx,
  input  logic [EA_W-1:0]      srWrData,
  input  logic                 cfgWrEn,
  input  logic [EA_W-1:0]      cfgBase,
  input  logic [SIZE_W-1:0]    cfgSize,
  input  logic [EA_W-1:0]      reqAddr,
  input  logic                 reqUser,
  input  strobe_t              stb,
  output logic                 segT,
  output logic                 segN,
  output logic                 segKey,
  output logic [VSID_W-1:0]    srchHash,
  output logic [PG_W-1:0]      srchPgIdx,
  output logic [EA_W-1:0]      srchTag,
  output faultClass_e          faultClass,
  output logic [EA_W-1:0]      faultAddr,
  output logic [EA_W-1:0]      cmpReg,
  output logic [EA_W-1:0]      hashAddr1,
  output logic [EA_W-1:0]      hashAddr2,
  output logic [EA_W-1:0]      statusWord,
  output logic [EA_W-1:0]      syndFlags,
  output logic [EA_W-1:0]      realAddr
);
  localparam int PAD_W = EA_W - VSID_W;

  logic [EA_W-1:0]   srFile [NSEG];
  logic [EA_W-1:0]   cfgBaseR;
  logic [SIZE_W-1:0] cfgSizeR;
  logic [EA_W-1:0]   curSr;
  logic [VSID_W-1:0] vsid;
  logic [VSID_W-1:0] hashMask;
  logic [5:0]        maskBits;
  logic [EA_W-1:0]   grpOff1;
  logic [EA_W-1:0]   grpOff2;
  logic              unusedSrBits;

  assign curSr        = srFile[reqAddr[EA_W-1 -: SEG_SEL_W]];
  assign segT         = curSr[31];
  assign segKey       = reqUser ? curSr[29] : curSr[30];
  assign segN         = curSr[28];
  assign vsid         = curSr[VSID_W-1:0];
  assign unusedSrBits = ^curSr[27:VSID_W];

  assign srchPgIdx = reqAddr[EA_W-SEG_SEL_W-1:PAGE_BITS];
  assign srchHash  = vsid ^ {{(VSID_W-PG_W){1'b0}}, srchPgIdx};
  assign srchTag   = ({{PAD_W{1'b0}}, vsid} << TAG_SHIFT) |
                     {{(EA_W-PG_W){1'b0}}, srchPgIdx >> API_SHIFT};

  always_comb begin
    maskBits = 6'(MIN_MASK_BITS) + {2'b00, cfgSizeR};
    if (maskBits >= 6'(VSID_W)) hashMask = '1;
    else                        hashMask = VSID_W'((32'd1 << maskBits) - 32'd1);
  end

  assign grpOff1 = {{PAD_W{1'b0}}, srchHash & hashMask} << GROUP_SHIFT;
  assign grpOff2 = {{PAD_W{1'b0}}, ~srchHash & hashMask} << GROUP_SHIFT;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NSEG; i++) srFile[i] <= '0;
      cfgBaseR <= '0;
      cfgSizeR <= '0;
    end else begin
      if (srWrEn) srFile[srWrIdx] <= srWrData;
      if (cfgWrEn) begin
        cfgBaseR <= cfgBase;
        cfgSizeR <= cfgSize;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      faultClass <= FC_OK;
      faultAddr  <= '0;
      cmpReg     <= '0;
      hashAddr1  <= '0;
      hashAddr2  <= '0;
      statusWord <= '0;
      syndFlags  <= '0;
      realAddr   <= '0;
    end else if (stb.cap) begin
      faultClass <= stb.fClass;
      faultAddr  <= stb.ldFault ? reqAddr : '0;
      cmpReg     <= stb.ldMiss ? (srchTag | 32'h8000_0000) : '0;
      hashAddr1  <= stb.ldMiss ? (cfgBaseR + grpOff1) : '0;
      hashAddr2  <= stb.ldMiss ? (cfgBaseR + grpOff2) : '0;
      statusWord <= stb.status;
      syndFlags  <= stb.synd;
      realAddr   <= stb.ldReal ? reqAddr : '0;
    end
  end
endmodule

// File: rtl/segx_top.sv
module segx_top
  import segx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 srWrEn,
  input  logic [SEG_SEL_W-1:0] srWrIdx,
  input  logic [EA_W-1:0]      srWrData,
  input  logic                 cfgWrEn,
  input  logic [EA_W-1:0]      cfgBase,
  input  logic [SIZE_W-1:0]    cfgSize,
  input  logic                 reqValid,
  input  logic [EA_W-1:0]      reqAddr,
  input  logic                 reqFetch,
  input  logic                 reqStore,
  input  logic                 reqUser,
  input  logic [KIND_W-1:0]    reqKind,
  output logic [VSID_W-1:0]    srchHash,
  output logic [PG_W-1:0]      srchPgIdx,
  output logic [EA_W-1:0]      srchTag,
  input  logic                 tlbMiss,
  input  logic                 tlbProt,
  output logic                 doneValid,
  output logic [2:0]           faultClass,
  output logic [EA_W-1:0]      faultAddr,
  output logic [EA_W-1:0]      cmpReg,
  output logic [EA_W-1:0]      hashAddr1,
  output logic [EA_W-1:0]      hashAddr2,
  output logic [EA_W-1:0]      statusWord,
  output logic [EA_W-1:0]      syndFlags,
  output logic [EA_W-1:0]      realAddr
);
  strobe_t     stb;
  logic        segT;
  logic        segN;
  logic        segKey;
  faultClass_e fClassQ;

  segx_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqFetch  (reqFetch),
    .reqStore  (reqStore),
    .reqKind   (reqKind),
    .segT      (segT),
    .segN      (segN),
    .segKey    (segKey),
    .tlbMiss   (tlbMiss),
    .tlbProt   (tlbProt),
    .stb       (stb),
    .doneValid (doneValid)
  );

  segx_dpath u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .srWrEn     (srWrEn),
    .srWrIdx    (srWrIdx),
    .srWrData   (srWrData),
    .cfgWrEn    (cfgWrEn),
    .cfgBase    (cfgBase),
    .cfgSize    (cfgSize),
    .reqAddr    (reqAddr),
    .reqUser    (reqUser),
    .stb        (stb),
    .segT       (segT),
    .segN       (segN),
    .segKey     (segKey),
    .srchHash   (srchHash),
    .srchPgIdx  (srchPgIdx),
    .srchTag    (srchTag),
    .faultClass (fClassQ),
    .faultAddr  (faultAddr),
    .cmpReg     (cmpReg),
    .hashAddr1  (hashAddr1),
    .hashAddr2  (hashAddr2),
    .statusWord (statusWord),
    .syndFlags  (syndFlags),
    .realAddr   (realAddr)
  );

  assign faultClass = fClassQ;
endmodule

// File: rtl/segx_checker.sv
module segx_checker (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic [31:0] reqAddr,
  input logic        doneValid,
  input logic [2:0]  faultClass,
  input logic [31:0] faultAddr,
  input logic [31:0] cmpReg,
  input logic [31:0] hashAddr1,
  input logic [31:0] hashAddr2,
  input logic [31:0] statusWord,
  input logic [31:0] syndFlags,
  input logic [31:0] realAddr
);
  assert_done_after_req_R3: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> doneValid);

  assert_no_spurious_done_R3: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !doneValid);

  assert_syndrome_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> ($stable(faultClass) && $stable(faultAddr) && $stable(cmpReg) &&
                   $stable(statusWord) && $stable(syndFlags) && $stable(realAddr)));

  assert_noexec_code_R4: assert property (@(posedge clk) disable iff (!rstN)
    (faultClass == 3'd3) |-> (syndFlags == 32'h1000_0000));

  assert_miss_cmp_valid_R5: assert property (@(posedge clk) disable iff (!rstN)
    (faultClass == 3'd1) |-> cmpReg[31]);

  assert_miss_groups_differ_R6: assert property (@(posedge clk) disable iff (!rstN)
    (faultClass == 3'd1) |-> (hashAddr1 != hashAddr2));

  assert_hit_clean_R8: assert property (@(posedge clk) disable iff (!rstN)
    (faultClass == 3'd0) |-> (syndFlags == 32'd0 && statusWord == 32'd0 && faultAddr == 32'd0));

  assert_pass_addr_R10: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (faultClass != 3'd5 || realAddr == $past(reqAddr)));
endmodule

bind segx_top segx_checker u_chk (.*);

// File: tb/segx_top_bench.sv
`timescale 1ns/1ps
module segx_top_bench;
  localparam real CLK_NS = 8.0;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        srWrEn = 1'b0;
  logic [3:0]  srWrIdx = '0;
  logic [31:0] srWrData = '0;
  logic        cfgWrEn = 1'b0;
  logic [31:0] cfgBase = '0;
  logic [3:0]  cfgSize = '0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        reqFetch = 1'b0;
  logic        reqStore = 1'b0;
  logic        reqUser = 1'b0;
  logic [2:0]  reqKind = '0;
  logic        tlbMiss = 1'b0;
  logic        tlbProt = 1'b0;
  logic [23:0] srchHash;
  logic [15:0] srchPgIdx;
  logic [31:0] srchTag;
  logic        doneValid;
  logic [2:0]  faultClass;
  logic [31:0] faultAddr, cmpReg, hashAddr1, hashAddr2, statusWord, syndFlags, realAddr;

  int checks = 0;
  int fails  = 0;

  logic [31:0] srShadow [16];
  logic [31:0] baseShadow = '0;
  logic [3:0]  sizeShadow = '0;

  logic [2:0]  eCls;
  logic [31:0] eFa, eCmp, eH1, eH2, eSt, eSy, eRa;

  segx_top u_segx_top (.*);

  always #(CLK_NS/2.0) clk = ~clk;

  initial begin
    #(CLK_NS * 200000.0);
    fails++;
    $display("FAIL watchdog expired");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic string clsTag(input logic [2:0] c);
    case (c)
      3'd0: return "R8";
      3'd1: return "R5";
      3'd2: return "R7";
      3'd3: return "R4";
      3'd4: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [31:0] grpAddr(input logic [23:0] h);
    int nb;
    logic [23:0] m;
    nb = 10 + int'(sizeShadow);
    m = (nb >= 24) ? 24'hFFFFFF : 24'((32'd1 << nb) - 1);
    return baseShadow + ({8'd0, h & m} * 32'd64);
  endfunction

  task automatic model(input logic [31:0] ea, input logic f, input logic s, input logic u,
                       input logic [2:0] k, input logic miss, input logic prot);
    logic [31:0] sr;
    logic [23:0] vs, h;
    logic [15:0] pg;
    logic key, st;
    sr = srShadow[ea[31:28]];
    vs = sr[23:0];
    pg = ea[27:12];
    h  = vs ^ {8'd0, pg};
    key = u ? sr[29] : sr[30];
    st = s & ~f;
    eCls = 0; eFa = 0; eCmp = 0; eH1 = 0; eH2 = 0; eSt = 0; eSy = 0; eRa = 0;
    if (!sr[31]) begin
      if (f && sr[28]) begin eCls = 3; eSy = 32'h1000_0000; eFa = ea; end
      else if (miss) begin
        eCls = 1; eFa = ea;
        eCmp = 32'h8000_0000 | ({8'd0, vs} * 32'd128) | {26'd0, pg[15:10]};
        eH1 = grpAddr(h); eH2 = grpAddr(~h);
        eSy = (32'(key) << 19) | (32'(f) << 18) | (32'(st) << 16);
      end else if (prot) begin
        eCls = 2; eFa = ea;
        if (f) eSy = 32'h0800_0000;
        else   eSt = st ? 32'h0A00_0000 : 32'h0800_0000;
      end
    end else if (f) begin
      eCls = 4; eSy = 32'h1000_0000; eFa = ea;
    end else if (k == 3'd4) begin
      eCls = 5; eRa = ea;
    end else if (k == 3'd1) begin
      eCls = 4; eFa = ea;
    end else if (k == 3'd2) begin
      eCls = 4; eFa = ea; eSt = st ? 32'h0600_0000 : 32'h0400_0000;
    end else if (k == 3'd3) begin
      eCls = 4; eFa = ea; eSt = st ? 32'h0610_0000 : 32'h0410_0000;
    end else if (st == key) begin
      eCls = 5; eRa = ea;
    end else begin
      eCls = 2; eFa = ea; eSt = st ? 32'h0A00_0000 : 32'h0800_0000;
    end
  endtask

  task automatic checkHeld(input string tag);
    chk(tag, "faultClass", {29'd0, faultClass}, {29'd0, eCls});
    chk(tag, "faultAddr", faultAddr, eFa);
    chk(tag, "cmpReg", cmpReg, eCmp);
    chk(eCls == 3'd1 ? "R6" : tag, "hashAddr1", hashAddr1, eH1);
    chk(eCls == 3'd1 ? "R6" : tag, "hashAddr2", hashAddr2, eH2);
    chk(tag, "statusWord", statusWord, eSt);
    chk(tag, "syndFlags", syndFlags, eSy);
    chk(eCls == 3'd5 ? "R10" : tag, "realAddr", realAddr, eRa);
  endtask

  task automatic writeSr(input logic [3:0] idx, input logic [31:0] val);
    @(negedge clk);
    srWrEn = 1'b1; srWrIdx = idx; srWrData = val;
    @(negedge clk);
    srWrEn = 1'b0;
    srShadow[idx] = val;
  endtask

  task automatic writeCfg(input logic [31:0] b, input logic [3:0] sz);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgBase = b; cfgSize = sz;
    @(negedge clk);
    cfgWrEn = 1'b0;
    baseShadow = b; sizeShadow = sz;
  endtask

  task automatic doReq(input logic [31:0] ea, input logic f, input logic s, input logic u,
                       input logic [2:0] k, input logic miss, input logic prot, input logic holdChk);
    logic [31:0] sr;
    logic [15:0] pg;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = ea; reqFetch = f; reqStore = s; reqUser = u;
    reqKind = k; tlbMiss = miss; tlbProt = prot;
    #1;
    sr = srShadow[ea[31:28]];
    pg = ea[27:12];
    chk("R2", "srchPgIdx", {16'd0, srchPgIdx}, {16'd0, pg});
    chk("R2", "srchHash", {8'd0, srchHash}, {8'd0, sr[23:0] ^ {8'd0, pg}});
    chk("R2", "srchTag", srchTag, ({8'd0, sr[23:0]} * 32'd128) | {26'd0, pg[15:10]});
    model(ea, f, s, u, k, miss, prot);
    @(negedge clk);
    reqValid = 1'b0;
    chk("R3", "doneValid", {31'd0, doneValid}, 32'd1);
    checkHeld(clsTag(eCls));
    if (holdChk) begin
      reqAddr = $urandom; tlbMiss = ~miss; tlbProt = ~prot; reqFetch = ~f;
      @(negedge clk);
      @(negedge clk);
      chk("R3", "doneValid idle", {31'd0, doneValid}, 32'd0);
      checkHeld("R3");
    end
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5EED_0042);
    for (int i = 0; i < 16; i++) srShadow[i] = '0;
    repeat (3) @(negedge clk);
    #1;
    // R11: reset state
    chk("R11", "doneValid", {31'd0, doneValid}, 32'd0);
    eCls = 0; eFa = 0; eCmp = 0; eH1 = 0; eH2 = 0; eSt = 0; eSy = 0; eRa = 0;
    checkHeld("R11");
    chk("R11", "srchHash seg0", {8'd0, srchHash}, 32'd0);
    rstN = 1'b1;

    // R1: segment selection and field decode
    writeSr(4'd5, 32'h0012_3456);
    writeSr(4'd6, 32'h0065_4321);
    @(negedge clk);
    reqAddr = 32'h5000_0000; #1;
    chk("R1", "seg5 hash", {8'd0, srchHash}, 32'h0012_3456);
    reqAddr = 32'h6000_0000; #1;
    chk("R1", "seg6 hash", {8'd0, srchHash}, 32'h0065_4321);

    writeCfg(32'h0010_0000, 4'd2);
    writeSr(4'd3, 32'h500A_BCDE);   // Ks=1 Kp=0 N=1 normal
    writeSr(4'd4, 32'h2001_2345);   // Kp=1 N=0 normal
    writeSr(4'd9, 32'hA000_0777);   // direct-store Ks=0 Kp=1

    doReq(32'h3123_4567, 1, 0, 0, 0, 1, 0, 1);  // R4 noexec, TLB ignored
    doReq(32'h4ABC_D000, 1, 0, 0, 0, 1, 0, 1);  // R5 fetch miss key 0
    doReq(32'h4ABC_D000, 0, 0, 1, 0, 1, 0, 0);  // R5 load miss user key 1
    doReq(32'h3FFF_F000, 0, 1, 0, 0, 1, 0, 0);  // R5 store miss sup key 1
    doReq(32'h4000_1000, 0, 1, 0, 0, 0, 1, 0);  // R7 store prot
    doReq(32'h4000_1000, 0, 0, 0, 0, 0, 1, 0);  // R7 load prot
    doReq(32'h4000_1000, 1, 0, 0, 0, 0, 1, 0);  // R7 fetch prot
    doReq(32'h4000_1000, 0, 0, 0, 0, 0, 0, 1);  // R8 hit
    doReq(32'h9000_0040, 1, 0, 0, 0, 0, 0, 0);  // R9 ds fetch
    doReq(32'h9000_0040, 0, 1, 0, 1, 0, 0, 0);  // R9 float
    doReq(32'h9000_0040, 0, 1, 0, 2, 1, 0, 0);  // R9 reserved store
    doReq(32'h9000_0040, 0, 0, 0, 2, 0, 0, 0);  // R9 reserved load
    doReq(32'h9000_0040, 0, 1, 0, 3, 0, 0, 0);  // R9 external store
    doReq(32'h9000_0040, 0, 0, 0, 3, 0, 1, 0);  // R9 external load
    doReq(32'h9123_4560, 0, 0, 0, 4, 0, 0, 1);  // R10 cache pass
    doReq(32'h9123_4560, 0, 0, 0, 0, 0, 0, 0);  // R10 int load key0 pass
    doReq(32'h9123_4560, 0, 1, 1, 0, 0, 0, 0);  // R10 int store key1 pass
    doReq(32'h9123_4560, 0, 1, 0, 0, 0, 0, 0);  // R10 int store key0 prot
    doReq(32'h9123_4560, 0, 0, 1, 0, 0, 0, 0);  // R10 int load key1 prot

    // R6: mask capped at 24 bits with the largest size code
    writeSr(4'd7, 32'h00FF_FFFF);
    writeCfg(32'h8000_0000, 4'd15);
    doReq(32'h7000_3000, 0, 0, 0, 0, 1, 0, 0);
    writeCfg(32'h0000_0000, 4'd0);
    doReq(32'h7FFF_F000, 0, 1, 0, 0, 1, 0, 0);

    // constrained random
    for (int n = 0; n < 400; n++) begin
      if (n % 40 == 0) begin
        writeSr(4'($urandom), {$urandom} & 32'hF0FF_FFFF);
        writeCfg({$urandom} & 32'hFFFF_FFC0, 4'($urandom));
      end
      doReq($urandom, ($urandom % 4) == 0, 1'($urandom), 1'($urandom),
            3'($urandom % 5), ($urandom % 3) == 0, 1'($urandom), (n % 8) == 0);
    end

    repeat (2) @(negedge clk);
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule